// File: doc/BRIEF.md
# Dual-Pin Toggle Compare Timer

This block is a 16-bit up-counter that advances once per count-source tick while its run bit is set, together with four compare registers (A, B, C, D) and two toggling outputs, P and Q. The counter returns to zero on the tick where it equals register A. The period is therefore A+1 ticks. The other three compare values only mark points inside that period; the counter runs straight through them.

Output P inverts its level when the counter hits A and again when it hits C. Output Q inverts when the counter hits B and again when it hits D. Each output therefore gives a waveform with two programmable edges per period. Every compare register has a sticky hit flag. Only a write to the flag-clear address lowers a flag. Each output has its own enable. While the enable is low the output reads low, but its internal level keeps following the matches.

Software reaches the block through a simple write port. Addresses 0 to 3 load compare registers A to D. Address 4 clears flags. Address 5 loads the counter directly.

Top module: `twin_toggle_timer`

## Requirements
- R1: Reset puts the counter at 0000h, both internal output levels low, all four flags at 0 and every compare register at FFFFh.
- R2: The counter advances by one only on a clock edge where both `run` and `tick` are 1. A cycle with `tick` low leaves the counter and the outputs unchanged.
- R3: On a tick where the counter equals register A, the counter goes to 0000h, which gives a period of A+1 ticks.
- R4: A match on a tick inverts P for register A or C and inverts Q for register B or D. The new level shows on the pin after that clock edge.
- R5: When two registers that steer the same output match on the same tick, that output inverts once per register, so equal values cancel and the level holds.
- R6: `flags` bit 0 belongs to A, bit 1 to B, bit 2 to C and bit 3 to D. A match sets its bit. A write to address 4 clears exactly the bits given as 1 in `wr_data[3:0]`. Zero bits, and writes to any other address, leave the flags as they are.
- R7: A flag-clear write in the same cycle as a match on that register leaves the flag set.
- R8: While an output enable is 0, its pin reads 0. The internal level goes on toggling, and the pin shows that level as soon as the enable returns to 1.
- R9: With `run` at 0, the counter, the output levels and the flags hold, even while ticks arrive.
- R10: A write to address 5 loads `wr_data` into the counter, and this load takes priority over a tick in the same cycle. With no A match on the way, the counter wraps from FFFFh to 0000h.
- R11: Matches with B, C or D neither clear nor stop the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 compare A-D, 4 flag clear, 5 counter load |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count-source tick, one clock wide |
| run | input | 1 | Start bit; 0 freezes the timer |
| oe_p | input | 1 | Enable for output P |
| oe_q | input | 1 | Enable for output Q |
| pin_p | output | 1 | Output P |
| pin_q | output | 1 | Output Q |
| flags | output | 4 | Sticky hit flags, bit 0 = A to bit 3 = D |

## Verification
The hardest situation to reach is a flag-clear write that lands in exactly the cycle in which the same register matches. The stimulus gets there by issuing a clear of all four flags on every tick of a long stretch, so each match in that stretch coincides with a clear. The counter wrap is also hard to reach from the ports, because a free run from zero takes 65536 ticks. The stimulus instead loads the counter to just below FFFFh through address 5, with A set above the wrap point.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  localparam int NUM_CMP  = 4;
  localparam int NUM_PINS = 2;
  localparam int ADDR_W   = 3;

  // write-port address map; compare registers sit at their own index
  typedef enum logic [ADDR_W-1:0] {
    REG_CMP_A    = 3'd0,
    REG_CMP_B    = 3'd1,
    REG_CMP_C    = 3'd2,
    REG_CMP_D    = 3'd3,
    REG_FLAG_CLR = 3'd4,
    REG_CNT_LOAD = 3'd5
  } reg_addr_e;

  // which compare channels steer which output: P <- A,C ; Q <- B,D
  function automatic logic [NUM_CMP-1:0] pin_mask(input int pin_idx);
    return (pin_idx == 0) ? 4'b0101 : 4'b1010;
  endfunction

  // one inversion per matching channel: odd count flips, even count holds
  function automatic logic toggle_parity(input logic [NUM_CMP-1:0] hits,
                                         input logic [NUM_CMP-1:0] mask);
    return ^(hits & mask);
  endfunction

  // a new hit outranks a clear request in the same cycle
  function automatic logic [NUM_CMP-1:0] merge_flags(input logic [NUM_CMP-1:0] old,
                                                     input logic [NUM_CMP-1:0] hits,
                                                     input logic [NUM_CMP-1:0] clr);
    return (old & ~clr) | hits;
  endfunction
endpackage

// File: rtl/ttt_regs.sv
module ttt_regs
  import ttt_pkg::*;
#(
  parameter int W = 16,
  parameter int N = NUM_CMP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [W-1:0]         wr_data,
  output logic [N-1:0][W-1:0]  cmp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cmp[i] <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++)
        if (wr_addr == ADDR_W'(i)) cmp[i] <= wr_data;
    end
  end
endmodule

// File: rtl/ttt_counter.sv
module ttt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                               input logic [W-1:0] p);
    return (c == p) ? '0 : c + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load_en) cnt <= load_val;
    else if (step)    cnt <= next_count(cnt, period);
  end

  assert_clear_on_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && cnt == period) |=> (cnt == '0));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && cnt != period) |=> (cnt == $past(cnt) + W'(1)));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_en) |=> $stable(cnt));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt == $past(load_val)));
endmodule

// File: rtl/ttt_match.sv
module ttt_match #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                step,
  input  logic [W-1:0]        cnt,
  input  logic [N-1:0][W-1:0] cmp,
  output logic [N-1:0]        hits
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = step && (cnt == cmp[i]);
  end
endmodule

// File: rtl/ttt_flags.sv
module ttt_flags
  import ttt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] hits,
  input  logic [NUM_CMP-1:0] clr,
  output logic [NUM_CMP-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= merge_flags(flags, hits, clr);
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    assert_hit_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hits[i] |=> flags[i]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
    assert_only_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !hits[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/ttt_pin.sv
module ttt_pin
  import ttt_pkg::*;
#(
  parameter logic [NUM_CMP-1:0] MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] hits,
  input  logic               oe,
  output logic               pin
);
  logic level;
  logic [NUM_CMP-1:0] own_hits;

  assign own_hits = hits & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level ^ toggle_parity(hits, MASK);
  end

  assign pin = oe & level;

  assert_single_hit_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(own_hits) == 1) |=> (level != $past(level)));

  assert_twin_hits_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(own_hits) == 2) |=> $stable(level));

  assert_no_hit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (own_hits == '0) |=> $stable(level));
endmodule

// File: rtl/twin_toggle_timer.sv
module twin_toggle_timer
  import ttt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic               tick,
  input  logic               run,
  input  logic               oe_p,
  input  logic               oe_q,
  output logic               pin_p,
  output logic               pin_q,
  output logic [3:0]         flags
);
  logic                         step;
  logic                         load_en;
  logic [NUM_CMP-1:0]           clr_req;
  logic [NUM_CMP-1:0]           hits;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_PINS-1:0]          oe_vec;
  logic [NUM_PINS-1:0]          pin_vec;

  assign step    = run && tick;
  assign load_en = wr_en && (wr_addr == REG_CNT_LOAD);
  assign clr_req = (wr_en && wr_addr == REG_FLAG_CLR) ? wr_data[NUM_CMP-1:0] : '0;
  assign oe_vec  = {oe_q, oe_p};

  ttt_regs #(.W(CNT_W), .N(NUM_CMP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp(cmp)
  );

  ttt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load_en(load_en),
    .load_val(wr_data), .period(cmp[0]), .cnt(cnt)
  );

  ttt_match #(.W(CNT_W), .N(NUM_CMP)) u_match (
    .step(step), .cnt(cnt), .cmp(cmp), .hits(hits)
  );

  ttt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hits(hits), .clr(clr_req), .flags(flags)
  );

  for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
    ttt_pin #(.MASK(pin_mask(j))) u_pin (
      .clk(clk), .rst_n(rst_n), .hits(hits), .oe(oe_vec[j]), .pin(pin_vec[j])
    );
  end

  assign pin_p = pin_vec[0];
  assign pin_q = pin_vec[1];

  // R11: a B/C/D hit without an A hit never sends the counter to zero
  assert_side_hits_keep_counting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && !hits[0] && (hits[3:1] != '0)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R8: a disabled output never drives high
  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_p |-> !pin_p) and (!oe_q |-> !pin_q));
endmodule

// File: tb/twin_toggle_timer_tb.sv
`timescale 1ns/1ps
module twin_toggle_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        run = 1'b0;
  logic        oe_p = 1'b0;
  logic        oe_q = 1'b0;
  logic        pin_p, pin_q;
  logic [3:0]  flags;

  always #2.5 clk = ~clk;

  twin_toggle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .run(run), .oe_p(oe_p), .oe_q(oe_q),
    .pin_p(pin_p), .pin_q(pin_q), .flags(flags)
  );

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int vectors = 0;
  int miscompares = 0;

  // independent reference state
  logic [15:0] m_cnt;
  logic [15:0] m_reg [4];
  logic        m_lp, m_lq;
  logic [3:0]  m_flags;

  task automatic compare(input string tag, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: {p,q,flags} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: one expected item per clock edge, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.tag, {pin_p, pin_q, flags}, e.v);
    end
  end

  task automatic model_reset();
    m_cnt = '0; m_lp = 1'b0; m_lq = 1'b0; m_flags = '0;
    for (int k = 0; k < 4; k++) m_reg[k] = 16'hFFFF;
  endtask

  // driver: applies one clock of stimulus and pushes what the ports must show after it
  task automatic step(input bit wr, input logic [2:0] a, input logic [15:0] d,
                      input bit tk, input bit rn, input bit op, input bit oq,
                      input string tag);
    logic [3:0] hit;
    logic [3:0] clr;
    exp_t e;
    @(negedge clk);
    wr_en = wr; wr_addr = a; wr_data = d; tick = tk; run = rn; oe_p = op; oe_q = oq;
    hit = '0;
    if (tk && rn)
      for (int k = 0; k < 4; k++) hit[k] = (m_cnt == m_reg[k]);
    clr = (wr && a == 3'd4) ? d[3:0] : 4'd0;
    for (int k = 0; k < 4; k++) begin
      if (clr[k]) m_flags[k] = 1'b0;
      if (hit[k]) m_flags[k] = 1'b1;
    end
    if (hit[0]) m_lp = ~m_lp;
    if (hit[2]) m_lp = ~m_lp;
    if (hit[1]) m_lq = ~m_lq;
    if (hit[3]) m_lq = ~m_lq;
    if (wr && a == 3'd5)  m_cnt = d;
    else if (tk && rn)    m_cnt = (m_cnt == m_reg[0]) ? 16'd0 : m_cnt + 16'd1;
    if (wr && a < 3'd4)   m_reg[a] = d;
    e.v = {op & m_lp, oq & m_lq, m_flags};
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(1, a, d, 0, 1, 1, 1, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'd0, 16'd0, 1, 1, 1, 1, tag);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    wr_en = 0; tick = 0; run = 0; oe_p = 1; oe_q = 1;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    compare("R1 reset", {pin_p, pin_q, flags}, 6'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    reset_dut();

    // R4: A=9 (period 10), P flips at 9 and 5, Q flips at 3 and 7
    wr(3'd0, 16'd9, "R4 write A");
    wr(3'd1, 16'd3, "R4 write B");
    wr(3'd2, 16'd5, "R4 write C");
    wr(3'd3, 16'd7, "R4 write D");
    ticks(25, "R4 toggles");
    ticks(10, "R3 period A+1");

    // R6: zero bits clear nothing, set bits clear exactly their flag
    wr(3'd4, 16'h0000, "R6 clear none");
    wr(3'd4, 16'h0002, "R6 clear B only");
    wr(3'd1, 16'd3, "R6 other address");
    wr(3'd4, 16'h000F, "R6 clear all");

    // R2: ticks gated
    for (int i = 0; i < 12; i++) step(0, 3'd0, 16'd0, i[0], 1, 1, 1, "R2 tick gating");

    // R9: run low freezes everything
    for (int i = 0; i < 8; i++) step(0, 3'd0, 16'd0, 1, 0, 1, 1, "R9 frozen");
    ticks(6, "R9 resume");

    // R8: enables low mask the pins; levels keep moving
    for (int i = 0; i < 12; i++) step(0, 3'd0, 16'd0, 1, 1, 0, i[1], "R8 oe low");
    ticks(4, "R8 oe back");

    // R7: clear-all on every tick, so each match coincides with a clear
    for (int i = 0; i < 25; i++) step(1, 3'd4, 16'h000F, 1, 1, 1, 1, "R7 clear vs hit");

    // R5: C equals A so P never moves; D equals B so Q never moves
    wr(3'd2, 16'd9, "R5 write C=A");
    wr(3'd3, 16'd3, "R5 write D=B");
    ticks(25, "R5 cancel");

    // R11: side matches spread out, counter keeps going
    wr(3'd1, 16'd2, "R11 write B");
    wr(3'd2, 16'd4, "R11 write C");
    wr(3'd3, 16'd8, "R11 write D");
    ticks(30, "R11 keep counting");

    // R3: short period from a known count
    wr(3'd5, 16'd0, "R3 load 0");
    wr(3'd0, 16'd3, "R3 write A=3");
    ticks(12, "R3 short period");

    // R10: load near the top, wrap through FFFF with A out of the way
    wr(3'd0, 16'd20, "R10 write A");
    wr(3'd3, 16'd1, "R10 write D");
    step(1, 3'd5, 16'hFFFD, 1, 1, 1, 1, "R10 load beats tick");
    ticks(10, "R10 wrap");

    // R1: reset in the middle of activity
    reset_dut();
    ticks(12, "R1 after reset");

    step(0, 3'd0, 16'd0, 0, 1, 1, 1, "R2 idle");
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule